// File: doc/BRIEF.md
# Booth Radix-2 Sequential Signed Multiplier

This block multiplies two signed two's complement numbers of `WIDTH` bits over several clock cycles. Each cycle uses one adder and a one-bit shift. A single-cycle `start` pulse captures the multiplicand and the multiplier. The block then runs exactly `WIDTH` steps. In each step, the lowest multiplier bit and the bit shifted out before it choose one of three actions: add the multiplicand, subtract it, or do nothing. The accumulator, the multiplier register and the trailing bit are then shifted right arithmetically as one unit.

When the last step completes, `done` pulses for one cycle. The `2*WIDTH`-bit product sits on `product` and holds its value until the next accepted start. Negative operands need no sign correction afterwards, because the shift keeps the accumulator's sign. The accumulator carries one guard bit above `WIDTH`, so a most-negative multiplicand can be subtracted without wrapping.

Top module: `booth_mult`

## Requirements
- R1: After reset, `done` and `busy` are 0 and `product` is all zeros.
- R2: A `start` pulse while `busy` is 0 captures both operands, clears the accumulator and the trailing bit, and sets `busy` from the next cycle.
- R3: When the multiplier's bit 0 is 1 and the trailing bit is 0, the step subtracts the multiplicand from the accumulator, formed as accumulator plus inverted multiplicand plus one.
- R4: When the multiplier's bit 0 is 0 and the trailing bit is 1, the step adds the multiplicand. For the pairs 00 and 11 the accumulator is left as it was.
- R5: After the add or subtract choice, accumulator, multiplier register and trailing bit shift right by one as a unit. The accumulator's sign bit is copied into the vacated top position, and the old multiplier bit 0 becomes the trailing bit.
- R6: Exactly `WIDTH` steps are run. `done` is first seen high `WIDTH` clock edges after the edge that accepted `start`.
- R7: `done` is high for a single cycle, and `product` does not change from then until the next accepted start.
- R8: A `start` pulse while `busy` is 1 is ignored: the running product finishes with the first operands and on time.
- R9: For every pair of `WIDTH`-bit signed operands, including most-negative times most-negative, `product` equals the signed product as a `2*WIDTH`-bit two's complement value.
- R10: With `WIDTH`=4, multiplicand 1101 (-3) times multiplier 0101 (5) gives `product` = 11110001 (-15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a multiply when the block is not busy |
| multiplicand | input | WIDTH | Signed multiplicand, sampled on accepted start |
| multiplier | input | WIDTH | Signed multiplier, sampled on accepted start |
| product | output | 2*WIDTH | Signed product: accumulator low bits above the multiplier register |
| done | output | 1 | One-cycle pulse when the product is ready |
| busy | output | 1 | High while steps are running |

## Verification
Several multiplier patterns are used: 0101 alternates the add and subtract actions in every step, 1111 and 0000 stay on the no-op pairs, and 1000 and 0111 move from a long run to a single edge. Together these separate a fault in the recoding from a fault in the shift. A most-negative multiplicand, and a most-negative times most-negative pair, expose a missing guard bit or a logical shift used where an arithmetic one is needed. A sweep over every 4-bit signed pair checks against a plain signed multiply. Directed runs cover the latency, the one-cycle done pulse, the product holding still afterwards, and a start pulse raised while a multiply is running.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } boothState_t;

  typedef struct packed {
    logic load;
    logic step;
  } boothStrb_t;

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output boothStrb_t strb,
  output logic       done,
  output logic       busy
);

  localparam int CW = $clog2(WIDTH + 1);

  boothState_t state, stateNext;
  logic [CW-1:0] stepCnt, stepCntNext;

  always_comb begin
    stateNext   = state;
    stepCntNext = stepCnt;
    strb.load   = 1'b0;
    strb.step   = 1'b0;
    unique case (state)
      ST_RUN: begin
        strb.step   = 1'b1;
        stepCntNext = stepCnt - CW'(1);
        if (stepCnt == CW'(1)) stateNext = ST_FIN;
      end
      default: begin
        if (start) begin
          strb.load   = 1'b1;
          stepCntNext = CW'(WIDTH);
          stateNext   = ST_RUN;
        end else begin
          stateNext = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state   <= stateNext;
      stepCnt <= stepCntNext;
    end
  end

  assign done = (state == ST_FIN);
  assign busy = (state == ST_RUN);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && stepCnt > CW'(1)) |=> (busy && stepCnt == $past(stepCnt) - CW'(1)));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

endmodule

// File: rtl/booth_dp.sv
module booth_dp
  import booth_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  boothStrb_t         strb,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product
);

  localparam int AW = WIDTH + 1;

  logic [AW-1:0]    accA;
  logic [AW-1:0]    regM;
  logic [WIDTH-1:0] regQ;
  logic             qm1;

  logic          doSub, doAdd;
  logic [AW-1:0] addend;
  logic [AW-1:0] sum;

  assign doSub  = regQ[0] & ~qm1;
  assign doAdd  = ~regQ[0] & qm1;
  assign addend = doSub ? ~regM : (doAdd ? regM : '0);
  assign sum    = accA + addend + AW'(doSub);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accA <= '0;
      regM <= '0;
      regQ <= '0;
      qm1  <= 1'b0;
    end else if (strb.load) begin
      accA <= '0;
      regM <= {multiplicand[WIDTH-1], multiplicand};
      regQ <= multiplier;
      qm1  <= 1'b0;
    end else if (strb.step) begin
      accA <= {sum[AW-1], sum[AW-1:1]};
      regQ <= {sum[0], regQ[WIDTH-1:1]};
      qm1  <= regQ[0];
    end
  end

  assign product = {accA[WIDTH-1:0], regQ};

  // R7
  product_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> $stable(product));

  // R5
  trail_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> qm1 == $past(regQ[0]));

  // R4
  noop_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && (regQ[0] == qm1)) |=> accA == {$past(accA[AW-1]), $past(accA[AW-1:1])});

  // R2
  load_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (accA == '0 && !qm1));

endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product,
  output logic               done,
  output logic               busy
);

  boothStrb_t strb;

  booth_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .done  (done),
    .busy  (busy)
  );

  booth_dp #(.WIDTH(WIDTH)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

endmodule

// File: tb/booth_mult_tb.sv
module booth_mult_tb_top;

  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   multiplicand = '0;
  logic [W-1:0]   multiplier = '0;
  logic [2*W-1:0] product;
  logic           done;
  logic           busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  booth_mult #(.WIDTH(W)) dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product),
    .done         (done),
    .busy         (busy)
  );

  // {multiplicand, multiplier, expected product}
  localparam logic [15:0] VECS [10] = '{
    16'hD5F1, // R10: -3 * 5
    16'h8840, // -8 * -8
    16'h7731, // 7 * 7
    16'h87C8, // -8 * 7
    16'h78C8, // 7 * -8
    16'h0800, // 0 * -8
    16'hFF01, // -1 * -1
    16'h5DF1, // 5 * -3
    16'h350F, // 3 * 5
    16'h81F8  // -8 * 1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runMul(input logic [W-1:0] m, input logic [W-1:0] q,
                        output logic [2*W-1:0] p, output int lat);
    @(negedge clk);
    multiplicand = m;
    multiplier   = q;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat   = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 40);
    p = product;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  initial begin
    logic [2*W-1:0] p;
    logic [2*W-1:0] held;
    int lat;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", 32'(done), 32'd0);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 product", 32'(product), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed vector table (R3 R4 R5 R9 R10)
    for (int i = 0; i < 10; i++) begin
      runMul(VECS[i][15:12], VECS[i][11:8], p, lat);
      check("R9 table product", 32'(p), 32'(VECS[i][7:0]));
      check("R6 latency", 32'(lat), 32'(W));
    end

    // R2: busy rises the cycle after start
    @(negedge clk);
    multiplicand = 4'h3;
    multiplier   = 4'h2;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", 32'(busy), 32'd1);
    repeat (W - 1) @(negedge clk);
    check("R6 no early done", 32'(done), 32'd0);
    @(negedge clk);
    check("R6 done on time", 32'(done), 32'd1);
    check("R3 R4 R5 product 3*2", 32'(product), 32'h06);
    held = product;
    @(negedge clk);
    // R7: one-cycle pulse and held product
    check("R7 done pulse", 32'(done), 32'd0);
    repeat (5) @(negedge clk);
    check("R7 product held", 32'(product), 32'(held));

    // R8: start while busy ignored
    @(negedge clk);
    multiplicand = 4'hD;
    multiplier   = 4'h5;
    start        = 1'b1;
    @(negedge clk);
    multiplicand = 4'h7;
    multiplier   = 4'h7;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R8 latency unchanged", 32'(lat), 32'(W));
    check("R8 first operands kept", 32'(product), 32'hF1);

    // R9: exhaustive sweep against signed multiply
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [W-1:0] m;
        logic [W-1:0] q;
        logic [2*W-1:0] expP;
        m = W'(i);
        q = W'(j);
        expP = (2*W)'(int'($signed(m)) * int'($signed(q)));
        runMul(m, q, p, lat);
        check("R9 sweep", 32'(p), 32'(expP));
      end
    end

    finishRun();
  end

endmodule